// File: doc/BRIEF.md
# Flow-Controlled Asynchronous Serial Transmitter

This block serialises bytes onto a single transmit line. A producer writes a byte, together with an address/data flag, into a one-entry holding register with a load strobe. When a character boundary is reached, the byte moves into the shift logic and a frame is sent. A frame is a low start bit, eight data bits least significant first, an optional ninth flag bit, and one or two high stop bits. An external divider supplies a baud tick, and every bit lasts a fixed number of those ticks.

Flow control gates only the start of a character, and only when it is enabled. The active-low clear-to-send input passes through a short synchroniser. Its synchronised value is examined in the clock where the transmitter decides whether to begin the next frame. A frame that has begun always runs to the end of its last stop bit. When the holding register is refilled during a frame, the next frame follows with no idle time.

The transmit state machine has five states. TX_IDLE drives the line high. TX_START drives the start bit. TX_DATA shifts out the byte. TX_MP sends the flag bit. TX_STOP drives the stop bits. Its transitions are:
- launch: TX_IDLE to TX_START, on a tick with a full holding register and clearance given.
- start_done: TX_START to TX_DATA.
- next_bit: TX_DATA to TX_DATA.
- to_flag: TX_DATA to TX_MP, after bit 7 when the flag bit is on.
- to_stop: TX_DATA or TX_MP to TX_STOP.
- second_stop: TX_STOP to TX_STOP, when two stop bits were chosen.
- chain: TX_STOP to TX_START, when the next byte is waiting and cleared.
- rest: TX_STOP to TX_IDLE, otherwise.

Top module: `uart_tx_flow`

## Requirements
- R1: Out of reset the line `txd` is 1, `busy` is 0 and `hold_empty` is 1. Whenever `busy` is 0 the line is 1.
- R2: A `load` pulse while `hold_empty` is 1 captures `load_data` and `mp_bit`. `hold_empty` then stays 0 until the byte moves into the shift logic.
- R3: A `load` pulse while `hold_empty` is 0 is ignored. The held byte and flag are kept, and no extra frame results.
- R4: A frame begins only in the clock after a `baud_tick`, with a start bit of 0. Every bit of the frame lasts TICKS_PER_BIT baud ticks (default 16).
- R5: The eight data bits follow the start bit, bit 0 first and bit 7 last.
- R6: With `mp_en`=1 the captured flag value is sent as one extra bit between bit 7 and the stop bits. With `mp_en`=0 no extra bit is sent.
- R7: Stop bits are 1. `two_stop`=0 gives one stop bit and `two_stop`=1 gives two. `busy` falls at the end of the last stop bit.
- R8: With `cts_en`=0 the level of `cts_n` has no effect on when frames start.
- R9: With `cts_en`=1, a frame may begin only if `cts_n`, after a two-flop synchroniser, reads 0 in the clock where the start is decided. While it reads 1, a loaded byte stays held and the line stays idle.
- R10: Raising `cts_n` after a frame has begun, including during its stop bit, never shortens that frame.
- R11: If the holding register is full and clearance is given when the last stop bit ends, the next start bit follows with no gap. `hold_empty` rises in the same clock in which that start bit appears.
- R12: `mp_en` and `two_stop` are taken when a frame begins. Changing them during the frame does not alter its format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock pulse from the bit-rate divider |
| load | input | 1 | Write strobe for the holding register |
| load_data | input | DATA_W | Byte to transmit |
| mp_bit | input | 1 | Address/data flag captured with the byte |
| cts_en | input | 1 | Enables clear-to-send gating |
| mp_en | input | 1 | Enables the ninth flag bit |
| two_stop | input | 1 | Selects two stop bits when 1 |
| cts_n | input | 1 | Clear-to-send input, active low, asynchronous |
| txd | output | 1 | Serial transmit line |
| busy | output | 1 | A frame is in progress |
| hold_empty | output | 1 | Holding register can accept a byte |

## Verification
The hardest case to reach from the ports is withdrawal of clearance at a precise point in a running frame. This includes withdrawal inside the stop bit while a second byte already waits in the holding register. The bench forks a timer beside the frame decoder and raises `cts_n` at an offset counted from the observed falling edge of the start bit. It then checks three things: the running frame keeps its full length, the waiting byte stays held with the line idle, and that byte is sent once clearance returns. Back-to-back frames are reached by reloading the holding register in the clock after it empties, so that the chain transition is taken in every format of the sweep.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_MP,
        TX_STOP
    } tx_state_t;

endpackage

// File: rtl/uart_tx_sync.sv
// Multi-stage synchroniser for an asynchronous level, reset to a chosen value.
module uart_tx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/uart_tx_hold.sv
// One-entry holding register; writes while full are dropped.
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              flag_in,
    input  logic              take,
    output logic [DATA_W-1:0] dout,
    output logic              flag_out,
    output logic              full
);

    logic accept;

    assign accept = load && !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full     <= 1'b0;
            dout     <= '0;
            flag_out <= 1'b0;
        end else begin
            if (accept) begin
                full     <= 1'b1;
                dout     <= din;
                flag_out <= flag_in;
            end else if (take) begin
                full     <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_tx_fsm.sv
// Frame sequencer: start, data, optional flag, stop bits.
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_flag,
    input  logic              mp_en,
    input  logic              two_stop,
    input  logic              cts_ok,
    output logic              take,
    output logic              txd,
    output logic              busy
);

    localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_BIT - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    tx_state_t         state_q, state_d;
    logic [CNT_W-1:0]  tick_cnt_q;
    logic [IDX_W-1:0]  bit_idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              flag_q;
    logic              mp_mode_q;
    logic              two_q;
    logic              stop_idx_q;
    logic              go;
    logic              bit_end;
    logic              last_stop;

    assign go        = full && baud_tick && cts_ok;
    assign bit_end   = baud_tick && (tick_cnt_q == CNT_LAST);
    assign last_stop = (state_q == TX_STOP) && bit_end && (!two_q || stop_idx_q);
    assign take      = go && ((state_q == TX_IDLE) || last_stop);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (go) state_d = TX_START;                 // launch
            end
            TX_START: begin
                if (bit_end) state_d = TX_DATA;             // start_done
            end
            TX_DATA: begin
                if (bit_end && bit_idx_q == IDX_LAST) begin
                    state_d = mp_mode_q ? TX_MP : TX_STOP;  // to_flag / to_stop
                end
            end
            TX_MP: begin
                if (bit_end) state_d = TX_STOP;             // to_stop
            end
            TX_STOP: begin
                if (bit_end) begin
                    if (two_q && !stop_idx_q) state_d = TX_STOP;  // second_stop
                    else if (go)              state_d = TX_START; // chain
                    else                      state_d = TX_IDLE;  // rest
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt_q <= '0;
            bit_idx_q  <= '0;
            shift_q    <= '0;
            flag_q     <= 1'b0;
            mp_mode_q  <= 1'b0;
            two_q      <= 1'b0;
            stop_idx_q <= 1'b0;
        end else if (take) begin
            tick_cnt_q <= '0;
            bit_idx_q  <= '0;
            shift_q    <= hold_data;
            flag_q     <= hold_flag;
            mp_mode_q  <= mp_en;
            two_q      <= two_stop;
            stop_idx_q <= 1'b0;
        end else if (state_q != TX_IDLE && baud_tick) begin
            if (bit_end) begin
                tick_cnt_q <= '0;
                if (state_q == TX_DATA) begin
                    shift_q   <= shift_q >> 1;
                    bit_idx_q <= bit_idx_q + 1'b1;
                end
                if (state_q == TX_STOP) begin
                    stop_idx_q <= 1'b1;
                end
            end else begin
                tick_cnt_q <= tick_cnt_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy = (state_q != TX_IDLE);
        unique case (state_q)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shift_q[0];
            TX_MP:    txd = flag_q;
            TX_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    parameter int CTS_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              mp_bit,
    input  logic              cts_en,
    input  logic              mp_en,
    input  logic              two_stop,
    input  logic              cts_n,
    output logic              txd,
    output logic              busy,
    output logic              hold_empty
);

    logic              cts_s;
    logic              cts_ok;
    logic              full;
    logic              take;
    logic [DATA_W-1:0] hold_data;
    logic              hold_flag;

    uart_tx_sync #(
        .STAGES    (CTS_STAGES),
        .RESET_VAL (1'b1)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cts_n),
        .sync_out (cts_s)
    );

    assign cts_ok = !cts_en || !cts_s;

    uart_tx_hold #(
        .DATA_W (DATA_W)
    ) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .din      (load_data),
        .flag_in  (mp_bit),
        .take     (take),
        .dout     (hold_data),
        .flag_out (hold_flag),
        .full     (full)
    );

    uart_tx_fsm #(
        .DATA_W        (DATA_W),
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .full      (full),
        .hold_data (hold_data),
        .hold_flag (hold_flag),
        .mp_en     (mp_en),
        .two_stop  (two_stop),
        .cts_ok    (cts_ok),
        .take      (take),
        .txd       (txd),
        .busy      (busy)
    );

    assign hold_empty = !full;

endmodule

// File: rtl/uart_tx_flow_chk.sv
module uart_tx_flow_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic load,
    input logic cts_en,
    input logic cts_s,
    input logic txd,
    input logic busy,
    input logic hold_empty
);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R2
    no_fill_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_empty && !load) |=> hold_empty);

    // R4
    edge_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(baud_tick) |-> $stable(txd));

    // R7
    end_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> txd);

    // R9
    start_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hold_empty) && $past(cts_en)) |-> !$past(cts_s));

    // R11
    empty_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> (busy && !txd));

endmodule

bind uart_tx_flow uart_tx_flow_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .load       (load),
    .cts_en     (cts_en),
    .cts_s      (cts_s),
    .txd        (txd),
    .busy       (busy),
    .hold_empty (hold_empty)
);

// File: tb/test_uart_tx_flow.sv
module test_uart_tx_flow;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int TPB        = 16;
    localparam int BITCLK     = TPB * TICK_DIV;
    localparam int HALF       = BITCLK / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       load = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic       mp_bit = 1'b0;
    logic       cts_en = 1'b0;
    logic       mp_en = 1'b0;
    logic       two_stop = 1'b0;
    logic       cts_n = 1'b1;
    logic       txd;
    logic       busy;
    logic       hold_empty;

    int cyc = 0;
    int fall_cyc = 0;
    int prev_fall = 0;
    int prev_len = 0;
    int vectors = 0;
    int errors = 0;
    int div = 0;
    logic txd_d = 1'b1;

    uart_tx_flow i_uart_tx_flow (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .load       (load),
        .load_data  (load_data),
        .mp_bit     (mp_bit),
        .cts_en     (cts_en),
        .mp_en      (mp_en),
        .two_stop   (two_stop),
        .cts_n      (cts_n),
        .txd        (txd),
        .busy       (busy),
        .hold_empty (hold_empty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    always @(negedge clk) begin
        div = (div + 1) % TICK_DIV;
        baud_tick = (div == 0);
        if (txd_d === 1'b1 && txd === 1'b0) fall_cyc = cyc;
        txd_d = txd;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) step();
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic put(input logic [7:0] d, input logic f);
        load_data = d;
        mp_bit    = f;
        load      = 1'b1;
        step();
        load      = 1'b0;
    endtask

    task automatic wait_empty();
        while (hold_empty !== 1'b1) step();
    endtask

    // Decode one frame from the line and compare with the arithmetic expectation.
    task automatic decode(input logic [7:0] d, input logic f, input logic mpm,
                          input logic two, input logic chained, input logic gap_chk);
        int t;
        int nb;
        while (txd !== 1'b0) step();
        t  = fall_cyc;
        nb = 10 + int'(mpm) + int'(two);
        if (gap_chk) check("R11 no gap between frames", t - prev_fall, prev_len);
        wait_until(t + HALF);
        check("R4 start bit", txd, 1'b0);
        for (int i = 0; i < 8; i++) begin
            wait_until(t + HALF + BITCLK * (i + 1));
            check("R5 data bit order", txd, d[i]);
        end
        if (mpm) begin
            wait_until(t + HALF + BITCLK * 9);
            check("R6 flag bit after bit7", txd, f);
        end
        for (int s = 0; s < 1 + int'(two); s++) begin
            wait_until(t + HALF + BITCLK * (9 + int'(mpm) + s));
            check("R7 stop bit high", txd, 1'b1);
        end
        prev_fall = t;
        prev_len  = nb * BITCLK;
        if (!chained) begin
            while (busy !== 1'b0) step();
            check("R7 R10 full frame length", cyc - t, nb * BITCLK);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 txd after reset", txd, 1'b1);
        check("R1 busy after reset", busy, 1'b0);
        check("R1 hold_empty after reset", hold_empty, 1'b1);

        // Sweep of all formats with back-to-back frames (R5 R6 R7 R8 R11)
        for (int m = 0; m < 4; m++) begin
            mp_en    = m[0];
            two_stop = m[1];
            cts_en   = (m >= 2);
            cts_n    = (m < 2);      // R8: idle-high cts_n ignored when disabled
            for (int k = 0; k < 8; k++) step();
            put((m == 0) ? 8'h01 : 8'(m * 29 + 90), 1'b0);
            for (int j = 0; j < 6; j++) begin
                logic [7:0] cur;
                logic [7:0] nxt;
                cur = (m == 0) ? (8'h01 << j) : 8'(j * 73 + m * 29 + 90);
                nxt = (m == 0) ? (8'h01 << (j + 1)) : 8'((j + 1) * 73 + m * 29 + 90);
                wait_empty();
                if (j < 5) put(nxt, ~((j + 1) & 1) ^ m[0]);
                decode(cur, ~(j & 1) ^ m[0], m[0], m[1], j < 5, j > 0);
            end
        end

        // R9 clearance withheld, R3 load while full ignored
        mp_en = 1'b0; two_stop = 1'b0; cts_en = 1'b1; cts_n = 1'b1;
        for (int k = 0; k < 8; k++) step();
        put(8'hA5, 1'b0);
        put(8'h3C, 1'b1);
        for (int k = 0; k < 600; k++) step();
        check("R9 line idle while cts_n high", txd, 1'b1);
        check("R9 busy low while cts_n high", busy, 1'b0);
        check("R9 byte held while cts_n high", hold_empty, 1'b0);
        cts_n = 1'b0;
        decode(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R3 second load dropped, register empty", hold_empty, 1'b1);
        for (int k = 0; k < 300; k++) step();
        check("R3 no extra frame", txd, 1'b1);
        check("R3 no extra frame busy", busy, 1'b0);

        // R10 clearance withdrawn mid-frame with a byte waiting
        put(8'h96, 1'b0);
        wait_empty();
        put(8'h69, 1'b0);
        fork
            decode(8'h96, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            begin wait_until(fall_cyc + 100); cts_n = 1'b1; end
        join
        for (int k = 0; k < 400; k++) step();
        check("R9 waiting byte held after mid-frame withdrawal", hold_empty, 1'b0);
        check("R9 line idle after mid-frame withdrawal", txd, 1'b1);
        cts_n = 1'b0;
        decode(8'h69, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R10 withdrawal inside the stop bit, two stop bits and flag
        mp_en = 1'b1; two_stop = 1'b1;
        put(8'hC3, 1'b1);
        wait_empty();
        put(8'h18, 1'b0);
        fork
            decode(8'hC3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
            begin wait_until(fall_cyc + BITCLK * 10 + 8); cts_n = 1'b1; end
        join
        for (int k = 0; k < 300; k++) step();
        check("R10 stop-bit withdrawal holds next byte", hold_empty, 1'b0);
        cts_n = 1'b0;
        decode(8'h18, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);

        // R12 format fixed at frame start
        cts_en = 1'b0; cts_n = 1'b1; mp_en = 1'b0; two_stop = 1'b1;
        put(8'h5A, 1'b1);
        wait_empty();
        step();
        two_stop = 1'b0; mp_en = 1'b1;
        decode(8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R12 format kept, line idle after", txd, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule